// File: doc/BRIEF.md
# Serial Receive Holding Queue

This block sits between the bit-level receiver of a serial port and the host-facing register logic. It holds up to four received bytes in arrival order. It takes bytes from the deserializer and break indications from the line monitor. The host takes the oldest byte by pulsing a read strobe while the receive data register is accessed. The byte is presented combinationally on the read data port in that same cycle, and the queue advances at the next clock edge.

The queue drives three flags: receiver ready (at least one byte held), queue full (four bytes held) and a sticky break-change flag. It also drives a can-accept signal that tells the deserializer whether it may deliver a byte. A detected break stores a zero byte. When the queue is already full, that zero byte replaces the newest entry, so the break is never lost. A flush input, raised by the receiver reset command, discards all stored bytes.

Top module: `rxq_hold`

## Requirements
- R1: After reset the queue is empty and ready, full and break-change are all 0. Read data is 0x00 and can-accept equals the receiver enable input.
- R2: Bytes are released oldest first. While at least one byte is held, `rd_data` shows the oldest byte combinationally, and a read strobe removes it at the next clock edge.
- R3: `full` is 1 exactly when four bytes are held. `can_accept` is 1 exactly when `rx_en` is 1 and `full` is 0.
- R4: A read of a full queue clears `full` one cycle later unless a push in the same cycle brings the count back to four.
- R5: `rdy` is 1 in the cycle after any push that is not flushed. It drops only when a read leaves the queue empty, or on a flush.
- R6: A read strobe while the queue is empty sees `rd_data` = 0x00 and changes no state.
- R7: A push that arrives while four bytes are held overwrites the newest (fourth) entry. The count stays at four and the three older bytes are kept.
- R8: A break event sets `brk_flag` in the next cycle and pushes the byte 0x00. If a data push arrives in the same cycle, the data byte is discarded.
- R9: `brk_flag` stays set until `brk_clr` is pulsed. If a break event and `brk_clr` arrive in the same cycle, the flag is set.
- R10: A flush empties the queue and clears `rdy` and `full` in the next cycle. It overrides any read or push in the same cycle but does not touch `brk_flag`.
- R11: A read and a push in the same cycle act as a read followed by a push. The oldest byte leaves, and the new byte goes behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enabled |
| push_vld | input | 1 | Deserializer delivers a byte this cycle |
| push_data | input | DW | Byte from the deserializer |
| break_evt | input | 1 | Line monitor detected a break |
| rd_req | input | 1 | Host reads the receive data register |
| flush | input | 1 | Receiver reset: discard all bytes |
| brk_clr | input | 1 | Clear the break-change flag |
| rd_data | output | DW | Oldest byte, or 0x00 when empty |
| rdy | output | 1 | At least one byte held |
| full | output | 1 | Four bytes held |
| brk_flag | output | 1 | Sticky break-change flag |
| can_accept | output | 1 | Deserializer may deliver a byte |

## Verification
`rd_data` and `can_accept` are combinational from the current state. The bench checks them 1 ns after driving the inputs on the falling edge, before the rising edge that consumes them. `rdy`, `full` and `brk_flag` are registered and change on the rising edge after the stimulus. They are compared against the bench model at the next falling edge, after the model has applied that cycle's update. A bench function advances the model once per cycle, so every expected value refers to the same edge as the design.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    // Source of the byte entering the queue in a cycle
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_DATA  = 2'd1,
        SRC_BREAK = 2'd2
    } push_src_e;

    // A break outranks a deserializer byte in the same cycle
    function automatic push_src_e pick_src(input logic brk, input logic data);
        if (brk)       return SRC_BREAK;
        else if (data) return SRC_DATA;
        else           return SRC_NONE;
    endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] head
);
    logic [DW-1:0] ent_q [DEPTH];
    logic [DW-1:0] ent_d [DEPTH];

    // Each slot first takes its neighbour on a pop, then the write overrides
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] shifted;
        if (i == DEPTH - 1) begin : g_last
            assign shifted = ent_q[i];
        end else begin : g_mid
            assign shifted = pop ? ent_q[i+1] : ent_q[i];
        end
        assign ent_d[i] = (wr_en && (wr_idx == IW'(i))) ? wr_data : shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) ent_q[k] <= ent_d[k];
        end
    end

    assign head = ent_q[0];

    // R2: a pop moves the second entry to the head unless the head is rewritten
    a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !(wr_en && wr_idx == '0)) |=> (head == $past(ent_q[1])));
endmodule

// File: rtl/rxq_brkflag.sv
module rxq_brkflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R8: a break is seen in the flag one cycle later
    a_r8_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R9: the flag holds until cleared
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          push_vld,
    input  logic [DW-1:0] push_data,
    input  logic          break_evt,
    input  logic          rd_req,
    input  logic          flush,
    input  logic          brk_clr,
    output logic [DW-1:0] rd_data,
    output logic          rdy,
    output logic          full,
    output logic          brk_flag,
    output logic          can_accept
);
    import rxq_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = $clog2(DEPTH);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
        logic          full;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    push_src_e     src;
    logic          pop, wr_en, any_push;
    logic [IW-1:0] wr_idx;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] after_pop;
    logic [DW-1:0] head;

    always_comb begin
        src       = pick_src(break_evt, push_vld);
        any_push  = (src != SRC_NONE);
        pop       = rd_req && (ctl_q.cnt != '0) && !flush;
        after_pop = ctl_q.cnt - CW'(pop);
        wr_en     = any_push && !flush;
        wr_data   = (src == SRC_DATA) ? push_data : '0;
        wr_idx    = (after_pop == CNT_MAX) ? IW'(DEPTH - 1) : after_pop[IW-1:0];

        ctl_d = ctl_q;
        if (flush) begin
            ctl_d.cnt = '0;
        end else if (wr_en) begin
            ctl_d.cnt = (after_pop == CNT_MAX) ? CNT_MAX : after_pop + CW'(1);
        end else begin
            ctl_d.cnt = after_pop;
        end
        ctl_d.rdy  = (ctl_d.cnt != '0);
        ctl_d.full = (ctl_d.cnt == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (pop),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .head    (head)
    );

    rxq_brkflag u_brk (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (break_evt),
        .clr_i  (brk_clr),
        .flag_o (brk_flag)
    );

    assign rd_data    = (ctl_q.cnt != '0) ? head : '0;
    assign rdy        = ctl_q.rdy;
    assign full       = ctl_q.full;
    assign can_accept = rx_en && !ctl_q.full;

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= CNT_MAX);
    a_r7_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (full && any_push && !rd_req && !flush) |=> (full && ctl_q.cnt == CNT_MAX));
    a_r4_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd_req && !any_push && !flush) |=> !full);
    a_r5_push_sets_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        (any_push && !flush) |=> rdy);
    a_r6_empty_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rdy && !any_push && !flush) |=> ($stable(ctl_q.cnt) && !rdy));
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rdy && !full && rd_data == '0));
    a_r6_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> (rd_data == '0));
endmodule

// File: tb/rxq_hold_bench.sv
module rxq_hold_bench;
    localparam int DEPTH = 4;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0, push_vld = 1'b0, break_evt = 1'b0;
    logic          rd_req = 1'b0, flush = 1'b0, brk_clr = 1'b0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] rd_data;
    logic          rdy, full, brk_flag, can_accept;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] mq [DEPTH];
    int            mcnt = 0;
    bit            mbrk = 1'b0;

    always #5 clk = ~clk;

    rxq_hold #(.DEPTH(DEPTH), .DW(DW)) u_rxq_hold (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
        .push_data(push_data), .break_evt(break_evt), .rd_req(rd_req),
        .flush(flush), .brk_clr(brk_clr), .rd_data(rd_data), .rdy(rdy),
        .full(full), .brk_flag(brk_flag), .can_accept(can_accept)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_head();
        return (mcnt != 0) ? mq[0] : '0;
    endfunction

    // Advance the model by one clock edge for the given inputs
    function automatic void model_step(bit p, logic [DW-1:0] d, bit b, bit r, bit f, bit c);
        if (f) begin
            mcnt = 0;
        end else begin
            if (r && mcnt > 0) begin
                for (int k = 0; k < DEPTH - 1; k++) mq[k] = mq[k+1];
                mcnt--;
            end
            if (b || p) begin
                if (mcnt == DEPTH) mq[DEPTH-1] = b ? '0 : d;
                else begin
                    mq[mcnt] = b ? '0 : d;
                    mcnt++;
                end
            end
        end
        if (c) mbrk = 1'b0;
        if (b) mbrk = 1'b1;
    endfunction

    // One cycle: check registered flags, drive, check combinational outputs, advance model
    task automatic step(input string tag, input bit en, input bit p, input logic [DW-1:0] d,
                        input bit b, input bit r, input bit f, input bit c);
        @(negedge clk);
        chk(tag, "rdy (R5)", int'(rdy), int'(mcnt != 0));
        chk(tag, "full (R3)", int'(full), int'(mcnt == DEPTH));
        chk(tag, "brk_flag (R9)", int'(brk_flag), int'(mbrk));
        rx_en = en; push_vld = p; push_data = d; break_evt = b;
        rd_req = r; flush = f; brk_clr = c;
        #1;
        chk(tag, "rd_data (R2)", int'(rd_data), int'(model_head()));
        chk(tag, "can_accept (R3)", int'(can_accept), int'(en && mcnt != DEPTH));
        model_step(p, d, b, r, f, c);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "rdy", int'(rdy), 0);
        chk("R1", "full", int'(full), 0);
        chk("R1", "brk_flag", int'(brk_flag), 0);
        chk("R1", "rd_data", int'(rd_data), 0);
        chk("R1", "can_accept", int'(can_accept), 0);

        // R6: read of empty queue
        step("R6", 1, 0, 8'h00, 0, 1, 0, 0);
        step("R6", 1, 0, 8'h00, 0, 0, 0, 0);
        // R3/R5: fill to four
        step("R5", 1, 1, 8'hA1, 0, 0, 0, 0);
        step("R3", 1, 1, 8'hB2, 0, 0, 0, 0);
        step("R3", 1, 1, 8'hC3, 0, 0, 0, 0);
        step("R3", 1, 1, 8'hD4, 0, 0, 0, 0);
        // R7/R8: break while full overwrites the newest entry
        step("R7", 1, 0, 8'h00, 1, 0, 0, 0);
        step("R8", 1, 0, 8'h00, 0, 0, 0, 0);
        // R11/R4: read and break-push together while full
        step("R11", 1, 0, 8'h00, 1, 1, 0, 0);
        // R4: plain read clears full
        step("R4", 1, 0, 8'h00, 0, 1, 0, 0);
        step("R4", 1, 0, 8'h00, 0, 0, 0, 0);
        // R9: clear and set in the same cycle, then plain clear
        step("R9", 1, 0, 8'h00, 1, 0, 0, 1);
        step("R9", 1, 0, 8'h00, 0, 0, 0, 1);
        // R8: break and data together keep only the zero byte
        step("R8", 1, 1, 8'h5A, 1, 0, 0, 0);
        // R10: flush overrides push and read
        step("R10", 1, 1, 8'h77, 0, 1, 1, 0);
        step("R10", 1, 0, 8'h00, 0, 0, 0, 0);
        // R2: drain order after fresh fill
        step("R2", 1, 1, 8'h11, 0, 0, 0, 0);
        step("R2", 1, 1, 8'h22, 0, 0, 0, 0);
        step("R11", 1, 1, 8'h33, 0, 1, 0, 0);
        for (int n = 0; n < 4; n++) step("R2", 1, 0, 8'h00, 0, 1, 0, 0);

        // Constrained random mix
        for (int it = 0; it < 4000; it++) begin
            bit en, p, b, r, f, c;
            logic [DW-1:0] d;
            en = ($urandom % 8) != 0;
            p  = en && (mcnt != DEPTH) && (($urandom % 2) != 0);
            d  = DW'($urandom);
            b  = ($urandom % 20) == 0;
            r  = ($urandom % 3) == 0;
            f  = ($urandom % 50) == 0;
            c  = ($urandom % 15) == 0;
            step("R2", en, p, d, b, r, f, c);
        end
        step("R5", 1, 0, 8'h00, 0, 0, 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule